// File: doc/BRIEF.md
# Spread-Spectrum Transmit Preamble and Header Framer

This block produces the serial bit stream that a spread-spectrum transmitter hands to its scrambler at the start of each packet. A one-cycle start pulse, taken only while the framer is idle, captures the packet configuration. The framer then emits a run of synchronization ones, followed by the header fields that the link mode selects. The header closes with a CCITT CRC-16 check word that the framer computes on the fly.

After the header, the framer opens a valid/ready payload window. Payload bits pass straight through to the output until the number of bits named in the length field has been transferred. The framer then drops its busy flag and waits for the next start.

All output bits come before scrambling. The check word therefore covers unscrambled header bits. Every field goes out most significant bit first.

Top module: `dsss_hdr_framer`

## Requirements
- R1: While reset is asserted, and until the first accepted start after it, `busy_o`, `bit_valid_o` and `pay_ready_o` are all low.
- R2: A start pulse seen while idle captures all configuration inputs, and `busy_o` is high from the next cycle. Later changes to the configuration inputs do not alter the frame under way. A start pulse seen while busy is ignored, and the frame continues unchanged.
- R3: The frame opens with `pre_len_i` preamble bits, each equal to 1. A value above 256 is treated as 256. A value of 0 sends no preamble, and the first sync-word bit appears in the cycle after the start.
- R4: After the preamble, the header depends on `mode_i`. Code 0 sends the 16-bit sync word only. Code 1 sends the sync word and then the 16-bit check word. Codes 2 and 3 send the sync word, the 8-bit signal field, the 8-bit service field, the 16-bit length field and the check word, in that order. Every field is sent MSB first.
- R5: The check word uses polynomial x^16+x^12+x^5+1 with the register preset to all ones. It covers the signal, service and length bits in transmit order and never the sync word. The complemented remainder is sent MSB first. In mode code 1 no bits are protected, so the check word is 0x0000.
- R6: Preamble and header bits go out one per clock on consecutive cycles, with `bit_valid_o` high and `pay_ready_o` low.
- R7: After the header, `pay_ready_o` is high. In that state `bit_o` follows `pay_data_i` and `bit_valid_o` follows `pay_valid_i`. The window closes after exactly `len_i` transfers. A length of 0 ends the frame right after the header.
- R8: `busy_o` stays high through the cycle of the last payload transfer, or through the last header bit when the length is 0. It is low in the following cycle.
- R9: While idle, `bit_valid_o` and `pay_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-frame pulse |
| pre_len_i | input | 9 | Preamble length in bits (0 to 256, larger values clamp) |
| mode_i | input | 2 | Header mode code |
| sync_i | input | 16 | Sync word |
| sig_i | input | 8 | Signal field value |
| svc_i | input | 8 | Service field value |
| len_i | input | 16 | Length field value, which is also the payload bit count |
| pay_data_i | input | 1 | Payload bit |
| pay_valid_i | input | 1 | Payload bit present |
| pay_ready_o | output | 1 | Payload window open |
| bit_o | output | 1 | Serial bit toward the scrambler |
| bit_valid_o | output | 1 | `bit_o` carries a frame bit this cycle |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong phase or bit counter shows at the ports within one cycle. A field would start early or late, and the very next expected bit would mismatch. A miscounted preamble shifts every later bit by the same amount. A corrupted check register is only visible during the final 16 header bits. That check is strengthened by comparing every output bit against a behavioural model on every clock, across all four mode codes and a clamped preamble. A faulty length counter shows as `pay_ready_o` or `busy_o` dropping one transfer too early or too late.

// File: rtl/dsss_frm_pkg.sv
`timescale 1ns/1ps
package dsss_frm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_SYNC, PH_SIG, PH_SVC, PH_LEN, PH_CHK, PH_PAY
  } phase_e;

  localparam int SYNC_BITS = 16;
  localparam int SIG_BITS  = 8;
  localparam int SVC_BITS  = 8;
  localparam int LEN_BITS  = 16;
  localparam int CHK_BITS  = 16;
  localparam logic [CHK_BITS-1:0] CHK_POLY   = 16'h1021;
  localparam logic [CHK_BITS-1:0] CHK_PRESET = 16'hFFFF;

  // Header sequencing; the mode code picks the branch taken after the sync word.
  function automatic phase_e hdr_next(phase_e cur, logic [1:0] mode);
    phase_e nxt;
    case (cur)
      PH_PRE:  nxt = PH_SYNC;
      PH_SYNC: begin
        if (mode == 2'd0)      nxt = PH_PAY;
        else if (mode == 2'd1) nxt = PH_CHK;
        else                   nxt = PH_SIG;
      end
      PH_SIG:  nxt = PH_SVC;
      PH_SVC:  nxt = PH_LEN;
      PH_LEN:  nxt = PH_CHK;
      PH_CHK:  nxt = PH_PAY;
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/dsss_frm_rst_sync.sv
`timescale 1ns/1ps
module dsss_frm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dsss_frm_seq.sv
`timescale 1ns/1ps
module dsss_frm_seq
  import dsss_frm_pkg::*;
#(
  parameter int PRE_W   = 9,
  parameter int PRE_MAX = 256,
  parameter int LEN_W   = LEN_BITS,
  localparam int CNT_W  = (LEN_W > PRE_W) ? LEN_W : PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PRE_W-1:0] pre_len_i,
  input  logic [1:0]       mode_i,
  input  logic [LEN_W-1:0] pay_len_i,
  input  logic             pay_valid_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             accept_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       mode_q, mode_d;
  logic [LEN_W-1:0] plen_q, plen_d;
  logic             accept, step, last, cfg_en, seq_en;
  logic [CNT_W-1:0] pre_eff;
  phase_e           nxt;

  function automatic logic [CNT_W-1:0] load_of(phase_e p, logic [LEN_W-1:0] l);
    case (p)
      PH_SYNC: return CNT_W'(SYNC_BITS);
      PH_SIG:  return CNT_W'(SIG_BITS);
      PH_SVC:  return CNT_W'(SVC_BITS);
      PH_LEN:  return CNT_W'(LEN_BITS);
      PH_CHK:  return CNT_W'(CHK_BITS);
      PH_PAY:  return CNT_W'(l);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    accept  = start_i && (phase_q == PH_IDLE);
    pre_eff = (CNT_W'(pre_len_i) > CNT_W'(PRE_MAX)) ? CNT_W'(PRE_MAX) : CNT_W'(pre_len_i);
    step    = (phase_q == PH_PAY) ? pay_valid_i : (phase_q != PH_IDLE);
    last    = step && (cnt_q == CNT_W'(1));
    nxt     = hdr_next(phase_q, mode_q);
    cfg_en  = accept;
    seq_en  = accept || step;
    mode_d  = mode_i;
    plen_d  = pay_len_i;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (accept) begin
      if (pre_eff == '0) begin
        phase_d = PH_SYNC;
        cnt_d   = CNT_W'(SYNC_BITS);
      end else begin
        phase_d = PH_PRE;
        cnt_d   = pre_eff;
      end
    end else if (last) begin
      if (nxt == PH_PAY && plen_q == '0) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end else begin
        phase_d = nxt;
        cnt_d   = load_of(nxt, plen_q);
      end
    end else if (step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      plen_q <= '0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
      plen_q <= plen_d;
    end
  end

  assign phase_o  = phase_q;
  assign cnt_o    = cnt_q;
  assign accept_o = accept;
endmodule

// File: rtl/dsss_frm_crc16.sv
`timescale 1ns/1ps
module dsss_frm_crc16
  import dsss_frm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preset_i,
  input  logic                shift_i,
  input  logic                din_i,
  output logic [CHK_BITS-1:0] crc_o
);
  logic [CHK_BITS-1:0] crc_q, crc_d;
  logic                fb, crc_en;

  always_comb begin
    fb     = crc_q[CHK_BITS-1] ^ din_i;
    crc_en = preset_i || shift_i;
    if (preset_i) crc_d = CHK_PRESET;
    else          crc_d = {crc_q[CHK_BITS-2:0], 1'b0} ^ (fb ? CHK_POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CHK_PRESET;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/dsss_frm_fields.sv
`timescale 1ns/1ps
module dsss_frm_fields
  import dsss_frm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [SYNC_BITS-1:0] sync_i,
  input  logic [SIG_BITS-1:0]  sig_i,
  input  logic [SVC_BITS-1:0]  svc_i,
  input  logic [LEN_BITS-1:0]  len_i,
  input  phase_e               phase_i,
  input  logic [3:0]           idx_i,
  input  logic [CHK_BITS-1:0]  crc_i,
  output logic                 hdr_bit_o
);
  logic [SYNC_BITS-1:0] sync_q;
  logic [SIG_BITS-1:0]  sig_q;
  logic [SVC_BITS-1:0]  svc_q;
  logic [LEN_BITS-1:0]  len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      sig_q  <= '0;
      svc_q  <= '0;
      len_q  <= '0;
    end else if (load_i) begin
      sync_q <= sync_i;
      sig_q  <= sig_i;
      svc_q  <= svc_i;
      len_q  <= len_i;
    end
  end

  always_comb begin
    case (phase_i)
      PH_PRE:  hdr_bit_o = 1'b1;
      PH_SYNC: hdr_bit_o = sync_q[idx_i];
      PH_SIG:  hdr_bit_o = sig_q[idx_i[2:0]];
      PH_SVC:  hdr_bit_o = svc_q[idx_i[2:0]];
      PH_LEN:  hdr_bit_o = len_q[idx_i];
      PH_CHK:  hdr_bit_o = ~crc_i[idx_i];
      default: hdr_bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsss_hdr_framer.sv
`timescale 1ns/1ps
module dsss_hdr_framer
  import dsss_frm_pkg::*;
#(
  parameter int PRE_W   = 9,
  parameter int PRE_MAX = 256,
  localparam int CNT_W  = (LEN_BITS > PRE_W) ? LEN_BITS : PRE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [PRE_W-1:0]     pre_len_i,
  input  logic [1:0]           mode_i,
  input  logic [SYNC_BITS-1:0] sync_i,
  input  logic [SIG_BITS-1:0]  sig_i,
  input  logic [SVC_BITS-1:0]  svc_i,
  input  logic [LEN_BITS-1:0]  len_i,
  input  logic                 pay_data_i,
  input  logic                 pay_valid_i,
  output logic                 pay_ready_o,
  output logic                 bit_o,
  output logic                 bit_valid_o,
  output logic                 busy_o
);
  logic             rst_n_s;
  phase_e           phase_w;
  logic [CNT_W-1:0] cnt_w;
  logic [3:0]       idx_w;
  logic             accept_w, hdr_bit_w, crc_shift_w;
  logic [CHK_BITS-1:0] crc_w;

  dsss_frm_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  dsss_frm_seq #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX), .LEN_W(LEN_BITS)) seq_i (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .pre_len_i(pre_len_i),
    .mode_i(mode_i), .pay_len_i(len_i), .pay_valid_i(pay_valid_i),
    .phase_o(phase_w), .cnt_o(cnt_w), .accept_o(accept_w)
  );

  assign idx_w = 4'(cnt_w - CNT_W'(1));

  dsss_frm_fields fld_i (
    .clk(clk), .rst_n(rst_n_s), .load_i(accept_w), .sync_i(sync_i),
    .sig_i(sig_i), .svc_i(svc_i), .len_i(len_i), .phase_i(phase_w),
    .idx_i(idx_w), .crc_i(crc_w), .hdr_bit_o(hdr_bit_w)
  );

  assign crc_shift_w = (phase_w == PH_SIG) || (phase_w == PH_SVC) || (phase_w == PH_LEN);

  dsss_frm_crc16 crc_i (
    .clk(clk), .rst_n(rst_n_s), .preset_i(accept_w), .shift_i(crc_shift_w),
    .din_i(hdr_bit_w), .crc_o(crc_w)
  );

  always_comb begin
    pay_ready_o = (phase_w == PH_PAY);
    busy_o      = (phase_w != PH_IDLE);
    if (phase_w == PH_PAY) begin
      bit_o       = pay_data_i;
      bit_valid_o = pay_valid_i;
    end else begin
      bit_o       = hdr_bit_w;
      bit_valid_o = (phase_w != PH_IDLE);
    end
  end
endmodule

// File: rtl/dsss_frm_checker.sv
`timescale 1ns/1ps
module dsss_frm_checker
  import dsss_frm_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                busy_o,
  input logic                bit_o,
  input logic                bit_valid_o,
  input logic                pay_ready_o,
  input phase_e              phase,
  input logic [CHK_BITS-1:0] crc
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bit_valid_o && !pay_ready_o));

  p_pre_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRE) |-> bit_o);

  p_hdr_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !pay_ready_o) |-> bit_valid_o);

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && phase != PH_PRE) |=> (phase != PH_PRE));

  p_chk_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHK) |=> ((phase == PH_CHK) -> $stable(crc)));

  p_ready_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready_o |-> busy_o);

  p_pay_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready_o && !busy_o) |-> 1'b0);
endmodule

bind dsss_hdr_framer dsss_frm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .bit_o(bit_o),
  .bit_valid_o(bit_valid_o), .pay_ready_o(pay_ready_o), .phase(phase_w), .crc(crc_w)
);

// File: tb/dsss_hdr_framer_tb_top.sv
`timescale 1ns/1ps
module dsss_hdr_framer_tb_top;
  logic        clk;
  logic        rst_n, start_i, pay_data_i, pay_valid_i;
  logic [8:0]  pre_len_i;
  logic [1:0]  mode_i;
  logic [15:0] sync_i, len_i;
  logic [7:0]  sig_i, svc_i;
  logic        pay_ready_o, bit_o, bit_valid_o, busy_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit hq[$];
  string tq[$];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  dsss_hdr_framer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pre_len_i(pre_len_i),
    .mode_i(mode_i), .sync_i(sync_i), .sig_i(sig_i), .svc_i(svc_i), .len_i(len_i),
    .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_field(input int val, input int w, input string tag);
    for (int i = w - 1; i >= 0; i--) begin
      hq.push_back(bit'((val >> i) & 1));
      tq.push_back(tag);
    end
  endtask

  function automatic int crc_of(input int sig, input int svc, input int len, input bit full);
    int c = 'hFFFF;
    int word = ((sig & 'hFF) << 24) | ((svc & 'hFF) << 16) | (len & 'hFFFF);
    if (full) begin
      for (int i = 31; i >= 0; i--) begin
        int b  = (word >> i) & 1;
        int fb = ((c >> 15) & 1) ^ b;
        c = (c << 1) & 'hFFFF;
        if (fb != 0) c = c ^ 'h1021;
      end
    end
    return (~c) & 'hFFFF;
  endfunction

  task automatic check_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      chk(busy_o == 1'b0, "R9", "idle busy", int'(busy_o), 0);
      chk(bit_valid_o == 1'b0, "R9", "idle valid", int'(bit_valid_o), 0);
      chk(pay_ready_o == 1'b0, "R9", "idle ready", int'(pay_ready_o), 0);
    end
  endtask

  task automatic run_frame(input int pre, input int mode, input int sync, input int sig,
                           input int svc, input int len, input int seed, input int poke_at);
    int pe;
    int rem;
    int cyc;
    bit vld, dat;
    pe = (pre > 256) ? 256 : pre;
    hq.delete();
    tq.delete();
    for (int i = 0; i < pe; i++) begin hq.push_back(1'b1); tq.push_back("R3"); end
    push_field(sync, 16, "R4");
    if (mode >= 2) begin
      push_field(sig, 8, "R4");
      push_field(svc, 8, "R4");
      push_field(len, 16, "R4");
    end
    if (mode != 0) push_field(crc_of(sig, svc, len, mode >= 2), 16, "R5");
    @(negedge clk);
    pre_len_i = 9'(pre); mode_i = 2'(mode); sync_i = 16'(sync);
    sig_i = 8'(sig); svc_i = 8'(svc); len_i = 16'(len);
    start_i = 1'b1;
    @(negedge clk);
    // R2: disturb configuration after capture
    sync_i = ~sync_i; sig_i = ~sig_i; svc_i = ~svc_i; len_i = len_i + 16'd5;
    mode_i = ~mode_i; pre_len_i = 9'd7;
    rem = len;
    cyc = 0;
    forever begin
      vld = ((cyc * 7 + seed) % 5) != 0;
      dat = bit'(((cyc * 3 + seed) >> 1) & 1);
      pay_valid_i = vld;
      pay_data_i  = dat;
      start_i     = (cyc == poke_at);
      #1;
      if (hq.size() > 0) begin
        bit e = hq.pop_front();
        string t = tq.pop_front();
        chk(bit_valid_o == 1'b1, "R6", "hdr valid", int'(bit_valid_o), 1);
        chk(pay_ready_o == 1'b0, "R6", "hdr ready", int'(pay_ready_o), 0);
        chk(bit_o == e, t, "hdr bit", int'(bit_o), int'(e));
        chk(busy_o == 1'b1, "R8", "busy in hdr", int'(busy_o), 1);
      end else if (rem > 0) begin
        chk(pay_ready_o == 1'b1, "R7", "pay ready", int'(pay_ready_o), 1);
        chk(bit_valid_o == vld, "R7", "pay valid", int'(bit_valid_o), int'(vld));
        if (vld) chk(bit_o == dat, "R7", "pay bit", int'(bit_o), int'(dat));
        chk(busy_o == 1'b1, "R8", "busy in pay", int'(busy_o), 1);
        if (vld) rem--;
      end else begin
        chk(busy_o == 1'b0, "R8", "busy after end", int'(busy_o), 0);
        chk(bit_valid_o == 1'b0, "R9", "valid after end", int'(bit_valid_o), 0);
        chk(pay_ready_o == 1'b0, "R9", "ready after end", int'(pay_ready_o), 0);
        break;
      end
      cyc++;
      if (cyc > 3000) begin
        chk(1'b0, "R8", "frame too long", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    pay_valid_i = 1'b0;
    check_idle(3);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; pay_data_i = 1'b0; pay_valid_i = 1'b0;
    pre_len_i = '0; mode_i = '0; sync_i = '0; sig_i = '0; svc_i = '0; len_i = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy_o == 1'b0, "R1", "reset busy", int'(busy_o), 0);
    chk(bit_valid_o == 1'b0, "R1", "reset valid", int'(bit_valid_o), 0);
    chk(pay_ready_o == 1'b0, "R1", "reset ready", int'(pay_ready_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check_idle(4);
    // R4 R5 full header, payload with gaps
    run_frame(5, 2, 'hF3A0, 'h0A, 'h5C, 12, 1, -1);
    // R3 zero preamble, R4 sync only
    run_frame(0, 0, 'h1234, 'hFF, 'h00, 3, 2, -1);
    // R5 check word over nothing, R7 zero length
    run_frame(3, 1, 'hB44C, 'h14, 'h77, 0, 3, -1);
    // R3 clamp, R2 start while busy, mode code 3
    run_frame(300, 3, 'h05CF, 'hA5, 'h3C, 4, 4, 3);
    // R2 start in payload phase, single-bit preamble and payload
    run_frame(1, 2, 'hFFFF, 'h00, 'hFF, 1, 0, 66);
    run_frame(256, 1, 'h0001, 'h81, 'h42, 20, 5, 200);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule